// File: doc/BRIEF.md
# Reset pin qualifier

This block cleans up an asynchronous, active-low hardware reset pin before the rest of a storage device controller acts on it. It samples the pin with a fast local clock and passes it through a synchronizer. A width counter then accepts a level change only after the new level has held for a set number of samples. Short spikes of either polarity are dropped. A low pulse that is wide enough, followed by its release, counts as a valid reset request.

The internal reset fires on the qualified release of the pin, not while the pin is held low. After the release the block waits out a command hold-off in fast-clock ticks. It also counts rising edges of the host interface clock. It raises a ready-for-command flag only when both conditions are met. A configuration bit can disable the pin function. A sticky error flag records a low pulse that was too short to accept, seen after an accepted reset.

Top module: `rpf_reset_cond`

## Requirements
- R1: After the synchronous reset `rst`, `rst_pulse`, `cmd_ready` and `short_err` are all 0.
- R2: A low level on `pin_rst_n` lasting at least MIN_TICKS fast-clock cycles is accepted. `rst_pulse` is high for exactly one cycle, and it appears SYNC_STAGES+MIN_TICKS rising clock edges after the pin returns high. A low level shorter than MIN_TICKS cycles gives no pulse.
- R3: The reset is triggered by the release edge. While the pin stays low, no `rst_pulse` occurs, however long the low lasts. An accepted low drops `cmd_ready` SYNC_STAGES+MIN_TICKS+1 edges after the pin falls, and `cmd_ready` is 0 while `rst_pulse` is high.
- R4: While an accepted low is in force, a high spike shorter than MIN_TICKS cycles does not end it. The single `rst_pulse` is timed from the final release.
- R5: If enough interface clock edges have already arrived, `cmd_ready` rises exactly SYNC_STAGES+MIN_TICKS+HOLD_TICKS+2 edges after the pin release. It never rises sooner than HOLD_TICKS+1 cycles after `rst_pulse`.
- R6: `cmd_ready` stays 0 until IF_CYCLES rising edges of `if_clk` have been seen after `rst_pulse`. Edges before the pulse are not counted. Once the hold-off has expired, `cmd_ready` rises SYNC_STAGES+2 fast edges after the final counted `if_clk` rise.
- R7: While `rst_en` is 0, the pin is ignored. No `rst_pulse` is produced, `cmd_ready` keeps its value and `short_err` is not set. The next cycle after `rst_en` is low never shows a pulse.
- R8: After at least one accepted reset, a low pulse of GLITCH_TICKS up to MIN_TICKS-1 cycles sets `short_err` and produces no `rst_pulse`. The flag is sticky until `rst`. Shorter lows, and any low before the first accepted reset, leave it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_en | input | 1 | Configuration bit; 1 enables the reset pin function |
| pin_rst_n | input | 1 | Asynchronous active-low hardware reset pin |
| if_clk | input | 1 | Host interface clock, asynchronous to clk |
| rst_pulse | output | 1 | One-cycle internal reset on a qualified release |
| cmd_ready | output | 1 | High once the hold-off and interface clock count are both met |
| short_err | output | 1 | Sticky flag for a too-short low after an accepted reset |

## Verification
Every result is due a fixed number of fast-clock edges after its stimulus. The bench drives inputs on falling edges and counts falling-edge samples from each pin or interface-clock change. It expects the pulse at sample SYNC_STAGES+MIN_TICKS after the release and the ready flag at SYNC_STAGES+MIN_TICKS+HOLD_TICKS+2. After the last counted interface clock rise, it expects ready at SYNC_STAGES+2, with a zero check one sample earlier. A sweep of low widths from 1 to 12 checks acceptance and the error flag against the width thresholds. Error checks are made after a few settling samples.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

  // Event bundle passed from the width filter to the sequencer.
  typedef struct packed {
    logic level;      // qualified pin level, 1 = released
    logic rise;       // one-cycle strobe on a qualified release
    logic short_low;  // one-cycle strobe on a rejected low of notable width
  } flt_ev_t;

  function automatic int cnt_w(input int maxval);
    return (maxval < 1) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/rpf_sync.sv
module rpf_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= INIT;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= INIT;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rpf_width_filter.sv
module rpf_width_filter
  import rpf_pkg::*;
#(
  parameter int MIN_TICKS    = 250,
  parameter int GLITCH_TICKS = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  logic    sync_n,
  output flt_ev_t ev
);
  localparam int CW = cnt_w(MIN_TICKS);

  logic [CW-1:0] run_q;
  logic          lvl_q;
  logic          rise_q;
  logic          short_q;
  logic          differ;

  assign differ = (sync_n != lvl_q);

  // The level flips only after MIN_TICKS consecutive differing samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= 1'b1;
      run_q   <= '0;
      rise_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      rise_q  <= 1'b0;
      short_q <= 1'b0;
      if (!en) begin
        lvl_q <= 1'b1;
        run_q <= '0;
      end else if (differ) begin
        if (run_q == CW'(MIN_TICKS - 1)) begin
          lvl_q  <= sync_n;
          run_q  <= '0;
          rise_q <= sync_n;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        // A low run ended before qualifying.
        if (lvl_q && (run_q >= CW'(GLITCH_TICKS))) short_q <= 1'b1;
        run_q <= '0;
      end
    end
  end

  assign ev.level     = lvl_q;
  assign ev.rise      = rise_q;
  assign ev.short_low = short_q;
endmodule

// File: rtl/rpf_seq.sv
module rpf_seq
  import rpf_pkg::*;
#(
  parameter int HOLD_TICKS = 50000,
  parameter int IF_CYCLES  = 74
) (
  input  logic    clk,
  input  logic    rst,
  input  flt_ev_t ev,
  input  logic    ifc_sync,
  output logic    ready,
  output logic    err
);
  localparam int HW = cnt_w(HOLD_TICKS);
  localparam int KW = cnt_w(IF_CYCLES);

  logic [HW-1:0] hold_q;
  logic [KW-1:0] cc_q;
  logic          run_q;
  logic          ifp_q;
  logic          armed_q;
  logic          ready_q;
  logic          err_q;
  logic          if_edge;
  logic          hold_done;
  logic          cc_done;

  assign if_edge   = ifc_sync & ~ifp_q;
  assign hold_done = (hold_q == HW'(HOLD_TICKS));
  assign cc_done   = (cc_q == KW'(IF_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      cc_q    <= '0;
      run_q   <= 1'b0;
      ifp_q   <= 1'b0;
      armed_q <= 1'b0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ifp_q <= ifc_sync;
      if (ev.rise) begin
        run_q   <= 1'b1;
        hold_q  <= '0;
        cc_q    <= '0;
        armed_q <= 1'b1;
      end else if (!ev.level) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        if (!hold_done)           hold_q <= hold_q + 1'b1;
        if (if_edge && !cc_done)  cc_q   <= cc_q + 1'b1;
      end
      ready_q <= run_q && ev.level && !ev.rise && hold_done && cc_done;
      if (ev.short_low && armed_q) err_q <= 1'b1;
    end
  end

  assign ready = ready_q;
  assign err   = err_q;
endmodule

// File: rtl/rpf_reset_cond.sv
module rpf_reset_cond
  import rpf_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_TICKS    = 250,
  parameter int GLITCH_TICKS = 2,
  parameter int HOLD_TICKS   = 50000,
  parameter int IF_CYCLES    = 74
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_en,
  input  logic pin_rst_n,
  input  logic if_clk,
  output logic rst_pulse,
  output logic cmd_ready,
  output logic short_err
);
  logic    pin_sync;
  logic    ifc_sync;
  flt_ev_t ev;

  rpf_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_rst_n), .q(pin_sync)
  );

  rpf_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_ifc_sync (
    .clk(clk), .rst(rst), .d(if_clk), .q(ifc_sync)
  );

  rpf_width_filter #(.MIN_TICKS(MIN_TICKS), .GLITCH_TICKS(GLITCH_TICKS)) u_filter (
    .clk(clk), .rst(rst), .en(rst_en), .sync_n(pin_sync), .ev(ev)
  );

  rpf_seq #(.HOLD_TICKS(HOLD_TICKS), .IF_CYCLES(IF_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .ev(ev), .ifc_sync(ifc_sync),
    .ready(cmd_ready), .err(short_err)
  );

  assign rst_pulse = ev.rise;
endmodule

// File: rtl/rpf_reset_cond_chk.sv
module rpf_reset_cond_chk #(
  parameter int HOLD_TICKS = 50000
) (
  input logic clk,
  input logic rst,
  input logic rst_en,
  input logic rst_pulse,
  input logic cmd_ready,
  input logic short_err
);
  localparam int SW = $clog2(HOLD_TICKS + 2);

  logic [SW-1:0] since_q;
  logic          seen_q;

  // Cycles elapsed since the last internal reset pulse, saturating.
  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (rst_pulse) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != SW'(HOLD_TICKS + 1)) begin
      since_q <= since_q + 1'b1;
    end
  end

  a_r2_pulse_single: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |=> !rst_pulse);

  a_r3_ready_low_in_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |-> !cmd_ready);

  a_r5_holdoff_kept: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_ready) |-> (seen_q && (since_q >= SW'(HOLD_TICKS + 1))));

  a_r7_disabled_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !rst_en |=> !rst_pulse);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    short_err |=> short_err);
endmodule

bind rpf_reset_cond rpf_reset_cond_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk(clk), .rst(rst), .rst_en(rst_en), .rst_pulse(rst_pulse),
  .cmd_ready(cmd_ready), .short_err(short_err)
);

// File: tb/rpf_reset_cond_test.sv
`timescale 1ns/1ps
module rpf_reset_cond_test;
  localparam int S = 2;
  localparam int M = 8;
  localparam int G = 3;
  localparam int H = 40;
  localparam int C = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_en = 1'b1;
  logic pin = 1'b1;
  logic ifc_auto = 1'b0;
  logic ifc_tog = 1'b0;
  logic ifc_man = 1'b0;
  logic if_clk;
  logic rst_pulse, cmd_ready, short_err;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  assign if_clk = ifc_auto ? ifc_tog : ifc_man;

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (ifc_auto) ifc_tog = ~ifc_tog;
  end

  rpf_reset_cond #(.SYNC_STAGES(S), .MIN_TICKS(M), .GLITCH_TICKS(G),
                   .HOLD_TICKS(H), .IF_CYCLES(C)) uut (
    .clk(clk), .rst(rst), .rst_en(rst_en), .pin_rst_n(pin), .if_clk(if_clk),
    .rst_pulse(rst_pulse), .cmd_ready(cmd_ready), .short_err(short_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  // Hold the pin low for w samples, release, then watch for span samples.
  task automatic low_watch(input int w, input int span,
                           output int pk, output int np, output int rk);
    int lowp;
    lowp = 0;
    pin = 1'b0;
    for (int i = 0; i < w; i++) begin
      tick(1);
      if (rst_pulse) lowp++;
    end
    pin = 1'b1;
    pk = -1; np = lowp; rk = -1;
    for (int k = 1; k <= span; k++) begin
      tick(1);
      if (rst_pulse) begin np++; pk = k; end
      if (cmd_ready && rk < 0) rk = k;
    end
  endtask

  task automatic ifc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ifc_man = 1'b1; tick(2);
      ifc_man = 1'b0; tick(2);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int pk, np, rk;
    ifc_auto = 1'b1;
    do_reset();
    // R1 reset state
    check(rst_pulse == 1'b0, "R1 rst_pulse", rst_pulse, 0);
    check(cmd_ready == 1'b0, "R1 cmd_ready", cmd_ready, 0);
    check(short_err == 1'b0, "R1 short_err", short_err, 0);

    // R2 / R5 / R8 sweep over low widths following an accepted reset
    for (int w = 1; w <= 12; w++) begin
      bit acc, exp_err;
      do_reset();
      low_watch(12, 80, pk, np, rk);
      check(np == 1, "R2 accepted pulse count", np, 1);
      check(pk == S + M, "R2 pulse timing", pk, S + M);
      check(rk == S + M + H + 2, "R5 ready timing", rk, S + M + H + 2);
      acc = (w >= M);
      exp_err = (w >= G) && (w < M);
      low_watch(w, 30, pk, np, rk);
      check(np == int'(acc), "R2 width sweep pulse", np, int'(acc));
      if (acc) check(pk == S + M, "R2 width sweep timing", pk, S + M);
      check(short_err == exp_err, "R8 short error", short_err, int'(exp_err));
      tick(5);
      check(short_err == exp_err, "R8 sticky", short_err, int'(exp_err));
    end

    // R8 no error before any accepted reset
    do_reset();
    low_watch(5, 30, pk, np, rk);
    check(np == 0, "R8 unarmed no pulse", np, 0);
    check(short_err == 1'b0, "R8 unarmed no error", short_err, 0);

    // R3 long low gives no pulse until release; ready drop timing
    do_reset();
    low_watch(12, 80, pk, np, rk);
    check(cmd_ready == 1'b1, "R3 ready before fall", cmd_ready, 1);
    pin = 1'b0;
    tick(S + M);
    check(cmd_ready == 1'b1, "R3 ready held one edge", cmd_ready, 1);
    tick(1);
    check(cmd_ready == 1'b0, "R3 ready dropped", cmd_ready, 0);
    np = 0;
    for (int i = 0; i < 200; i++) begin
      tick(1);
      if (rst_pulse) np++;
    end
    check(np == 0, "R3 no pulse while low", np, 0);
    pin = 1'b1;
    pk = -1;
    for (int k = 1; k <= 20; k++) begin
      tick(1);
      if (rst_pulse) pk = k;
    end
    check(pk == S + M, "R3 pulse on release", pk, S + M);

    // R4 high spike during accepted low
    do_reset();
    pin = 1'b0; tick(12);
    pin = 1'b1; tick(4);
    pin = 1'b0;
    np = 0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (rst_pulse) np++;
    end
    check(np == 0, "R4 spike no pulse", np, 0);
    low_watch(1, 20, pk, np, rk);
    check(np == 1, "R4 single pulse", np, 1);
    check(pk == S + M, "R4 timed from final release", pk, S + M);

    // R6 interface clock counting
    ifc_auto = 1'b0;
    ifc_man = 1'b0;
    do_reset();
    pin = 1'b0; tick(12);
    ifc_pulses(C);
    pin = 1'b1;
    tick(100);
    check(cmd_ready == 1'b0, "R6 early edges ignored", cmd_ready, 0);
    ifc_pulses(C - 1);
    tick(20);
    check(cmd_ready == 1'b0, "R6 one edge short", cmd_ready, 0);
    ifc_man = 1'b1;
    tick(S + 1);
    check(cmd_ready == 1'b0, "R6 ready not yet", cmd_ready, 0);
    tick(1);
    check(cmd_ready == 1'b1, "R6 ready after last edge", cmd_ready, 1);
    ifc_man = 1'b0;
    tick(4);

    // R7 pin ignored when disabled
    rst_en = 1'b0;
    tick(2);
    low_watch(30, 40, pk, np, rk);
    check(np == 0, "R7 disabled no pulse", np, 0);
    check(cmd_ready == 1'b1, "R7 ready kept", cmd_ready, 1);
    low_watch(5, 20, pk, np, rk);
    check(short_err == 1'b0, "R7 disabled no error", short_err, 0);
    rst_en = 1'b1;
    tick(2);
    low_watch(12, 20, pk, np, rk);
    check(np == 1 && pk == S + M, "R7 re-enabled pulse", pk, S + M);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule